// File: doc/BRIEF.md
# Raster Timing and Status Flags

This block sits on the dot clock of a tile-based video generator that produces an NTSC-style raster. It counts dots across each scanline and scanlines down each frame. It marks which part of the frame is active: visible lines, the single post-render line, the vertical-blank lines and the single pre-render line. It also keeps the three flags that processor software polls: vertical blank, sprite overflow and sprite-0 hit.

The processor reads the status byte with a single-dot strobe. The read snapshots the flags into the `status` output, and the vertical-blank flag is consumed by that read. The sprite logic reports overflow and sprite-0 hits with single-dot pulses, and both sprite flags stay set until the end of vertical blank. An interrupt request is raised while the vertical-blank flag is set and the interrupt-enable control bit is high.

A read that lands on the very dot where vertical blank would begin returns the flag as clear and also stops the flag from being set in that frame, so no interrupt occurs in that frame. Software that polls the status byte can hit this race.

Top module: `raster_status_unit`

## Requirements
- R1: `dot` counts 0 to 340 and returns to 0. `line` advances by one on the dot that follows dot 340.
- R2: `line` counts 0 to 261 and returns to 0, giving 262 lines per frame.
- R3: Exactly one region output is high at all times. The regions are `in_visible` for lines 0–239, `in_post` for line 240, `in_vblank` for lines 241–260 and `in_pre` for line 261. The region outputs change on the same edge as `line`.
- R4: The vertical-blank flag is set by the edge at line 241, dot 1. It is reported in `status` bit 7.
- R5: A status read (`stat_rd` high at a clock edge) loads `status` with the flags as they stood before that edge. The same edge clears the vertical-blank flag.
- R6: At line 261, dot 1, the vertical-blank flag, the sprite-overflow flag and the sprite-0-hit flag all clear.
- R7: A pulse on `spr_ovf_set` sets the sprite-overflow flag, which is reported in `status` bit 5. Status reads and later lines do not clear it; only R6 does.
- R8: A pulse on `spr0_hit_set` sets the sprite-0-hit flag, reported in `status` bit 6, unless `spr0_hit_x` equals 255. A pulse at x = 255 has no effect. Only R6 clears the flag.
- R9: `status` bits 4:0 hold the value of `open_bus` sampled at the read edge. No write-activity flag is reported.
- R10: `nmi_req` is high one edge after both the vertical-blank flag and `nmi_en` are high, and it falls with the flag.
- R11: A read at line 241, dot 1 returns bit 7 as 0 and prevents the flag from being set in that frame, so `nmi_req` stays low through that vertical blank.
- R12: While `rst` is high, the counters, all flags, `status` and `nmi_req` are 0, and `in_visible` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_en | input | 1 | Interrupt enable control bit |
| stat_rd | input | 1 | Status-read strobe, one dot wide |
| open_bus | input | 5 | Stale bus value returned in status bits 4:0 |
| spr_ovf_set | input | 1 | Sprite-overflow set pulse |
| spr0_hit_set | input | 1 | Sprite-0 hit pulse |
| spr0_hit_x | input | 8 | Horizontal position of the sprite-0 hit |
| dot | output | 9 | Current dot within the line |
| line | output | 9 | Current scanline within the frame |
| in_visible | output | 1 | Visible line region |
| in_post | output | 1 | Post-render line region |
| in_vblank | output | 1 | Vertical-blank region |
| in_pre | output | 1 | Pre-render line region |
| nmi_req | output | 1 | Interrupt request |
| status | output | 8 | Status byte captured at the last read |

## Verification
A counter that slips by a single dot moves `dot`, `line` and the region outputs away from a free-running cycle count on the very next edge, so a comparison made every dot exposes it at once. A wrong flag state is seen at the next status read. It may also show up on `nmi_req` one edge after the set or clear dot. A missed end-of-blank clear stays hidden until the first read after line 261. For that reason the bench reads just before and just after that line, and also at the exact set dot where the race lies.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef struct packed {
    logic       vbl;
    logic       hit;
    logic       ovf;
    logic [4:0] bus;
  } status_t;

  typedef enum logic [1:0] {
    RGN_VISIBLE = 2'd0,
    RGN_POST    = 2'd1,
    RGN_VBLANK  = 2'd2,
    RGN_PRE     = 2'd3
  } region_e;

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int DOTS_PER_LINE = 341,
  parameter int TOTAL_LINES   = 262,
  parameter int DW            = 9,
  parameter int LW            = 9
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] dot_q,
  output logic [LW-1:0] line_q,
  output logic [DW-1:0] dot_nx,
  output logic [LW-1:0] line_nx
);

  localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS_PER_LINE - 1);
  localparam logic [LW-1:0] LAST_LINE = LW'(TOTAL_LINES - 1);

  logic end_of_line;

  always_comb begin
    end_of_line = (dot_q == LAST_DOT);
    dot_nx      = end_of_line ? '0 : dot_q + 1'b1;
    if (!end_of_line)
      line_nx = line_q;
    else if (line_q == LAST_LINE)
      line_nx = '0;
    else
      line_nx = line_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q  <= '0;
      line_q <= '0;
    end else begin
      dot_q  <= dot_nx;
      line_q <= line_nx;
    end
  end

endmodule

// File: rtl/raster_region.sv
module raster_region
  import raster_pkg::*;
#(
  parameter int VIS_LINES = 240,
  parameter int VBL_START = 241,
  parameter int PRE_START = 261,
  parameter int LW        = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] line_nx,
  output logic [3:0]    region_q
);

  region_e rgn;

  always_comb begin
    if (line_nx < LW'(VIS_LINES))
      rgn = RGN_VISIBLE;
    else if (line_nx < LW'(VBL_START))
      rgn = RGN_POST;
    else if (line_nx < LW'(PRE_START))
      rgn = RGN_VBLANK;
    else
      rgn = RGN_PRE;
  end

  always_ff @(posedge clk) begin
    if (rst)
      region_q <= 4'b0001;
    else
      region_q <= 4'b0001 << rgn;
  end

endmodule

// File: rtl/raster_flags.sv
module raster_flags
  import raster_pkg::*;
#(
  parameter int DW          = 9,
  parameter int LW          = 9,
  parameter int XW          = 8,
  parameter int VBL_START   = 241,
  parameter int PRE_START   = 261,
  parameter int SET_DOT     = 1,
  parameter int CLR_DOT     = 1,
  parameter int HIT_BLIND_X = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] dot_q,
  input  logic [LW-1:0] line_q,
  input  logic          stat_rd,
  input  logic          nmi_en,
  input  logic [4:0]    open_bus,
  input  logic          spr_ovf_set,
  input  logic          spr0_hit_set,
  input  logic [XW-1:0] spr0_hit_x,
  output status_t       status_q,
  output logic          nmi_q,
  output logic          vbl_q,
  output logic          hit_q,
  output logic          ovf_q
);

  logic at_set, at_clr, hit_ok;
  logic vbl_nx, hit_nx, ovf_nx;

  always_comb begin
    at_set = (line_q == LW'(VBL_START)) && (dot_q == DW'(SET_DOT));
    at_clr = (line_q == LW'(PRE_START)) && (dot_q == DW'(CLR_DOT));
    hit_ok = spr0_hit_set && (spr0_hit_x != XW'(HIT_BLIND_X));

    if (at_clr)
      vbl_nx = 1'b0;
    else if (at_set)
      vbl_nx = !stat_rd;
    else if (stat_rd)
      vbl_nx = 1'b0;
    else
      vbl_nx = vbl_q;

    hit_nx = at_clr ? 1'b0 : (hit_q | hit_ok);
    ovf_nx = at_clr ? 1'b0 : (ovf_q | spr_ovf_set);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbl_q    <= 1'b0;
      hit_q    <= 1'b0;
      ovf_q    <= 1'b0;
      nmi_q    <= 1'b0;
      status_q <= '0;
    end else begin
      vbl_q <= vbl_nx;
      hit_q <= hit_nx;
      ovf_q <= ovf_nx;
      nmi_q <= vbl_nx & nmi_en;
      if (stat_rd) begin
        status_q.vbl <= vbl_q;
        status_q.hit <= hit_q;
        status_q.ovf <= ovf_q;
        status_q.bus <= open_bus;
      end
    end
  end

endmodule

// File: rtl/raster_status_unit.sv
module raster_status_unit
  import raster_pkg::*;
#(
  parameter int DOTS_PER_LINE = 341,
  parameter int VIS_LINES     = 240,
  parameter int POST_LINES    = 1,
  parameter int VBL_LINES     = 20,
  parameter int PRE_LINES     = 1,
  parameter int XW            = 8,
  parameter int HIT_BLIND_X   = 255
) (
  input  logic                                                       clk,
  input  logic                                                       rst,
  input  logic                                                       nmi_en,
  input  logic                                                       stat_rd,
  input  logic [4:0]                                                 open_bus,
  input  logic                                                       spr_ovf_set,
  input  logic                                                       spr0_hit_set,
  input  logic [XW-1:0]                                              spr0_hit_x,
  output logic [$clog2(DOTS_PER_LINE)-1:0]                           dot,
  output logic [$clog2(VIS_LINES+POST_LINES+VBL_LINES+PRE_LINES)-1:0] line,
  output logic                                                       in_visible,
  output logic                                                       in_post,
  output logic                                                       in_vblank,
  output logic                                                       in_pre,
  output logic                                                       nmi_req,
  output logic [7:0]                                                 status
);

  localparam int TOTAL_LINES = VIS_LINES + POST_LINES + VBL_LINES + PRE_LINES;
  localparam int VBL_START   = VIS_LINES + POST_LINES;
  localparam int PRE_START   = VBL_START + VBL_LINES;
  localparam int DW          = $clog2(DOTS_PER_LINE);
  localparam int LW          = $clog2(TOTAL_LINES);

  logic [DW-1:0] dot_nx;
  logic [LW-1:0] line_nx;
  logic [3:0]    region_q;
  status_t       status_q;
  logic          vbl_flag, hit_flag, ovf_flag;

  raster_counter #(
    .DOTS_PER_LINE(DOTS_PER_LINE), .TOTAL_LINES(TOTAL_LINES), .DW(DW), .LW(LW)
  ) u_cnt (
    .clk(clk), .rst(rst), .dot_q(dot), .line_q(line),
    .dot_nx(dot_nx), .line_nx(line_nx)
  );

  raster_region #(
    .VIS_LINES(VIS_LINES), .VBL_START(VBL_START), .PRE_START(PRE_START), .LW(LW)
  ) u_rgn (
    .clk(clk), .rst(rst), .line_nx(line_nx), .region_q(region_q)
  );

  raster_flags #(
    .DW(DW), .LW(LW), .XW(XW), .VBL_START(VBL_START), .PRE_START(PRE_START),
    .SET_DOT(1), .CLR_DOT(1), .HIT_BLIND_X(HIT_BLIND_X)
  ) u_flg (
    .clk(clk), .rst(rst), .dot_q(dot), .line_q(line), .stat_rd(stat_rd),
    .nmi_en(nmi_en), .open_bus(open_bus), .spr_ovf_set(spr_ovf_set),
    .spr0_hit_set(spr0_hit_set), .spr0_hit_x(spr0_hit_x),
    .status_q(status_q), .nmi_q(nmi_req),
    .vbl_q(vbl_flag), .hit_q(hit_flag), .ovf_q(ovf_flag)
  );

  assign in_visible = region_q[RGN_VISIBLE];
  assign in_post    = region_q[RGN_POST];
  assign in_vblank  = region_q[RGN_VBLANK];
  assign in_pre     = region_q[RGN_PRE];
  assign status     = status_q;

endmodule

// File: rtl/raster_status_checker.sv
module raster_status_checker #(
  parameter int DW          = 9,
  parameter int LW          = 9,
  parameter int XW          = 8,
  parameter int LAST_DOT    = 340,
  parameter int VBL_START   = 241,
  parameter int PRE_START   = 261,
  parameter int HIT_BLIND_X = 255
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] dot,
  input logic [LW-1:0] line,
  input logic          in_visible,
  input logic          in_post,
  input logic          in_vblank,
  input logic          in_pre,
  input logic          stat_rd,
  input logic          spr0_hit_set,
  input logic [XW-1:0] spr0_hit_x,
  input logic          vbl_flag,
  input logic          hit_flag,
  input logic          ovf_flag,
  input logic          nmi_req,
  input logic [7:0]    status
);

  logic at_set, at_clr;
  assign at_set = (line == LW'(VBL_START)) && (dot == DW'(1));
  assign at_clr = (line == LW'(PRE_START)) && (dot == DW'(1));

  p_dot_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    dot == DW'(LAST_DOT) |=> dot == '0);

  p_dot_step_r1: assert property (@(posedge clk) disable iff (rst)
    dot != DW'(LAST_DOT) |=> dot == $past(dot) + 1'b1);

  p_one_region_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({in_visible, in_post, in_vblank, in_pre}) == 1);

  p_vbl_set_r4: assert property (@(posedge clk) disable iff (rst)
    at_set && !stat_rd |=> vbl_flag);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> !vbl_flag);

  p_end_clear_r6: assert property (@(posedge clk) disable iff (rst)
    at_clr |=> !vbl_flag && !hit_flag && !ovf_flag);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !at_clr |=> ovf_flag);

  p_no_hit_blind_r8: assert property (@(posedge clk) disable iff (rst)
    spr0_hit_set && spr0_hit_x == XW'(HIT_BLIND_X) && !hit_flag && !at_clr |=> !hit_flag);

  p_nmi_needs_flag_r10: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> vbl_flag);

  p_race_r11: assert property (@(posedge clk) disable iff (rst)
    at_set && stat_rd |=> !vbl_flag && !status[7] && !nmi_req);

endmodule

bind raster_status_unit raster_status_checker #(
  .DW(DW), .LW(LW), .XW(XW), .LAST_DOT(DOTS_PER_LINE - 1),
  .VBL_START(VBL_START), .PRE_START(PRE_START), .HIT_BLIND_X(HIT_BLIND_X)
) u_chk (
  .clk(clk), .rst(rst), .dot(dot), .line(line),
  .in_visible(in_visible), .in_post(in_post), .in_vblank(in_vblank), .in_pre(in_pre),
  .stat_rd(stat_rd), .spr0_hit_set(spr0_hit_set), .spr0_hit_x(spr0_hit_x),
  .vbl_flag(vbl_flag), .hit_flag(hit_flag), .ovf_flag(ovf_flag),
  .nmi_req(nmi_req), .status(status)
);

// File: tb/test_raster_status_unit.sv
module test_raster_status_unit;

  localparam int DOTS  = 341;
  localparam int LINES = 262;
  localparam int FRAME = DOTS * LINES;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmi_en = 1'b1;
  logic       stat_rd = 1'b0;
  logic [4:0] open_bus = '0;
  logic       spr_ovf_set = 1'b0;
  logic       spr0_hit_set = 1'b0;
  logic [7:0] spr0_hit_x = '0;
  logic [8:0] dot, line;
  logic       in_visible, in_post, in_vblank, in_pre, nmi_req;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int   n = 0;
  logic m_vbl = 0, m_hit = 0, m_ovf = 0, m_nmi = 0;
  logic [7:0] m_stat = '0;

  always #5 clk = ~clk;

  raster_status_unit i_raster_status_unit (
    .clk(clk), .rst(rst), .nmi_en(nmi_en), .stat_rd(stat_rd), .open_bus(open_bus),
    .spr_ovf_set(spr_ovf_set), .spr0_hit_set(spr0_hit_set), .spr0_hit_x(spr0_hit_x),
    .dot(dot), .line(line), .in_visible(in_visible), .in_post(in_post),
    .in_vblank(in_vblank), .in_pre(in_pre), .nmi_req(nmi_req), .status(status)
  );

  function automatic int pos_dot(int k);
    return k % DOTS;
  endfunction

  function automatic int pos_line(int k);
    return (k / DOTS) % LINES;
  endfunction

  function automatic logic [3:0] exp_region(int l); // {pre, vblank, post, visible}
    if (l < 240) return 4'b0001;
    if (l == 240) return 4'b0010;
    if (l < 261) return 4'b0100;
    return 4'b1000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (line %0d dot %0d)", req, act, exp,
               pos_line(n), pos_dot(n));
    end
  endtask

  // requirement-level model, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      n <= 0; m_vbl <= 0; m_hit <= 0; m_ovf <= 0; m_nmi <= 0; m_stat <= '0;
    end else begin
      logic v, h, o;
      int d, l;
      d = pos_dot(n);
      l = pos_line(n);
      v = m_vbl; h = m_hit; o = m_ovf;
      if (stat_rd) v = 1'b0;                        // R5
      if (l == 241 && d == 1) v = !stat_rd;         // R4, R11
      if (spr0_hit_set && spr0_hit_x != 8'd255) h = 1'b1; // R8
      if (spr_ovf_set) o = 1'b1;                    // R7
      if (l == 261 && d == 1) begin v = 0; h = 0; o = 0; end // R6
      if (stat_rd) m_stat <= {m_vbl, m_hit, m_ovf, open_bus}; // R5, R9
      m_vbl <= v; m_hit <= h; m_ovf <= o;
      m_nmi <= v & nmi_en;                          // R10
      n <= n + 1;
    end
  end

  // per-dot comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1 dot", 32'(dot), 32'(pos_dot(n)));
      check("R2 line", 32'(line), 32'(pos_line(n)));
      check("R3 region", 32'({in_pre, in_vblank, in_post, in_visible}), 32'(exp_region(pos_line(n))));
      check("R9 status", 32'(status), 32'(m_stat));
      check("R10 nmi", 32'(nmi_req), 32'(m_nmi));
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 reset dot", 32'(dot), 0);
    check("R12 reset line", 32'(line), 0);
    check("R12 reset status", 32'(status), 0);
    check("R12 reset nmi", 32'(nmi_req), 0);
    check("R12 reset region", 32'({in_pre, in_vblank, in_post, in_visible}), 32'h1);
    rst = 1'b0;

    for (int c = 0; c < FRAME + 246 * DOTS; c++) begin
      int d, l, f;
      @(negedge clk);
      d = pos_dot(n); l = pos_line(n); f = n / FRAME;

      // directed result checks (status reflects the read at the previous edge)
      if (f == 0 && l == 5 && d == 21) check("R8 x=255 ignored", 32'(status[6]), 0);
      if (f == 0 && l == 6 && d == 21) check("R8 hit set", 32'(status[6]), 1);
      if (f == 0 && l == 6 && d == 21) check("R9 open bus", 32'(status[4:0]), 32'h15);
      if (f == 0 && l == 7 && d == 21) check("R7 ovf set", 32'(status[5]), 1);
      if (f == 0 && l == 7 && d == 31) check("R7 ovf sticky after read", 32'(status[5]), 1);
      if (f == 0 && l == 241 && d == 2) check("R11 race bit7", 32'(status[7]), 0);
      if (f == 0 && l == 243 && d == 0) check("R11 no nmi", 32'(nmi_req), 0);
      if (f == 0 && l == 260 && d == 301) check("R11 flag stays clear", 32'(status[7]), 0);
      if (f == 0 && l == 260 && d == 301) check("R7 sprite flags before end", 32'(status[6:5]), 3);
      if (f == 0 && l == 261 && d == 21) check("R6 flags cleared", 32'(status[7:5]), 0);
      if (f == 1 && l == 241 && d == 1) check("R4 nmi low before set", 32'(nmi_req), 0);
      if (f == 1 && l == 241 && d == 2) check("R10 nmi raised", 32'(nmi_req), 1);
      if (f == 1 && l == 245 && d == 101) check("R4 vbl bit7 read", 32'(status[7]), 1);
      if (f == 1 && l == 245 && d == 101) check("R5 nmi drops on read", 32'(nmi_req), 0);
      if (f == 1 && l == 245 && d == 201) check("R5 bit7 cleared", 32'(status[7]), 0);

      // default and random stimulus
      stat_rd = 0; spr_ovf_set = 0; spr0_hit_set = 0;
      spr0_hit_x = 8'($urandom);
      open_bus = 5'($urandom);
      if (l >= 8 && l <= 238) begin
        stat_rd      = ($urandom % 64) == 0;
        spr0_hit_set = ($urandom % 256) == 0;
        spr_ovf_set  = ($urandom % 512) == 0;
        if (($urandom % 4096) == 0) nmi_en = ~nmi_en;
      end else begin
        nmi_en = 1'b1;
      end

      // directed stimulus
      if (f == 0 && l == 5 && d == 10) begin spr0_hit_set = 1; spr0_hit_x = 8'd255; end
      if (f == 0 && l == 6 && d == 10) begin spr0_hit_set = 1; spr0_hit_x = 8'd37; end
      if (f == 0 && l == 7 && d == 10) spr_ovf_set = 1;
      if (f == 0 && l == 239 && d == 5) spr_ovf_set = 1;
      if (f == 0 && l == 239 && d == 6) begin spr0_hit_set = 1; spr0_hit_x = 8'd3; end
      if (l == 6 && d == 20) open_bus = 5'h15;
      if (f == 0 && ((l == 5 && d == 20) || (l == 6 && d == 20) || (l == 7 && d == 20) ||
                     (l == 7 && d == 30) || (l == 241 && d == 1) || (l == 260 && d == 300) ||
                     (l == 261 && d == 20)))
        stat_rd = 1;
      if (f == 1 && l == 245 && (d == 100 || d == 200)) stat_rd = 1;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_990_000ns;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule